// File: doc/BRIEF.md
# Receive queue number composer

This block forms the 8-bit receive queue number for each classified ingress packet and hands it, with an RSS-enable flag, to the RSS lookup stage that follows. A queue number is split into a 5-bit high part and a 3-bit low part, and the full value is high × 8 + low. The low part always comes from the classifier result. The high part comes from the classifier unless software has pinned the ingress port to its own base, in which case it comes from a per-port base register.

The classifier supplies its queue fields from attribute word 0: the high part from bits 28:24 and the low part from bits 23:21. These fields arrive on separate ports. The RSS-enable bit from attribute word 2 passes straight through. Software programs, through a simple write port, a pin mask with one bit per port and one 5-bit base register per port. A base register normally holds the port's first queue shifted right by 3. With 32 queues per port, port 1 holds 4 and so only reaches queues 32 to 39. An oversize flag from the size check forces the port's base in the same way the pin mask does. The result is registered and appears one cycle after the input.

Top module: `rxq_composer`

## Requirements
- R1: After reset `out_valid_o`, `queue_o` and `rss_en_o` are 0, and the pin mask and all base registers are 0.
- R2: When `in_valid_i` is high at a clock edge, `out_valid_o` is high after that edge and `queue_o` equals high × 8 + low for that input. When `in_valid_i` is low, `out_valid_o` is low after the edge.
- R3: Bits 2:0 of `queue_o` always equal `cls_ql_i` of the accepted input.
- R4: When the pin-mask bit for `port_i` is 0 and `oversize_i` is 0, bits 7:3 of `queue_o` equal `cls_qh_i`.
- R5: When the pin-mask bit for `port_i` is 1, bits 7:3 of `queue_o` equal the base register of `port_i`, and `cls_qh_i` has no effect.
- R6: When `oversize_i` is 1, bits 7:3 of `queue_o` equal the base register of `port_i`, whatever the pin-mask bit.
- R7: `rss_en_o` equals `cls_rss_i` of the accepted input.
- R8: A write with address 0 loads the pin mask from `wr_data_i[3:0]`, where bit p is port p. A write with address 1+p loads the base of port p from `wr_data_i[4:0]`. Writes to addresses 5 to 7 change nothing. A write takes effect for inputs accepted after its edge.
- R9: While `in_valid_i` is low, `queue_o` and `rss_en_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 = pin mask, 1+p = base of port p |
| wr_data_i | input | 5 | Register write data |
| in_valid_i | input | 1 | Classified packet present |
| port_i | input | 2 | Ingress port number |
| cls_qh_i | input | 5 | Classifier queue high (attribute word 0 bits 28:24) |
| cls_ql_i | input | 3 | Classifier queue low (attribute word 0 bits 23:21) |
| cls_rss_i | input | 1 | Classifier RSS-enable attribute bit |
| oversize_i | input | 1 | Oversize flag, forces the port base |
| out_valid_o | output | 1 | Result valid |
| queue_o | output | 8 | Composed queue number |
| rss_en_o | output | 1 | RSS-enable flag passed through |

## Verification
The bench builds the block with its default parameters: 4 ports, a 5-bit high part and a 3-bit low part. At this size it can sweep all 16 pin-mask values against every port, both oversize states, all eight low values, a spread of high values and both RSS states. Base registers are loaded as port × 4, so an output that takes its high part from the wrong place or the wrong port gives a wrong number. Separate passes cover writes to unused addresses, the reset values and holding the output while no input is valid.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned QH_W = 5;
  localparam int unsigned QL_W = 3;
  localparam int unsigned Q_W  = QH_W + QL_W;

  typedef struct packed {
    logic [QH_W-1:0] qh;
    logic [QL_W-1:0] ql;
  } rxq_num_t;
endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_PORTS-1:0]             mask_o,
  output logic [NUM_PORTS-1:0][QH_W-1:0]   base_o
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 mask_o <= '0;
    else if (wr_en_i && wr_addr_i == MASK_ADDR)  mask_o <= wr_data_i[NUM_PORTS-1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_base
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(p + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 base_o[p] <= '0;
      else if (wr_en_i && wr_addr_i == BASE_ADDR)  base_o[p] <= wr_data_i[QH_W-1:0];
    end
  end

  // R8
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == MASK_ADDR) |=> mask_o == $past(wr_data_i[NUM_PORTS-1:0]));
endmodule

// File: rtl/rxq_select.sv
module rxq_select
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic [PORT_W-1:0]                port_i,
  input  logic                             oversize_i,
  input  logic [QH_W-1:0]                  cls_qh_i,
  input  logic [QL_W-1:0]                  cls_ql_i,
  input  logic [NUM_PORTS-1:0]             mask_i,
  input  logic [NUM_PORTS-1:0][QH_W-1:0]   base_i,
  output rxq_num_t                         q_o
);
  logic use_base;

  // low part never overridden; high part pinned by mask or oversize
  assign use_base = mask_i[port_i] | oversize_i;
  assign q_o.ql   = cls_ql_i;
  assign q_o.qh   = use_base ? base_i[port_i] : cls_qh_i;
endmodule

// File: rtl/rxq_composer.sv
module rxq_composer
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS),
  localparam int unsigned DATA_W   = (NUM_PORTS > QH_W) ? NUM_PORTS : QH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              in_valid_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [QH_W-1:0]   cls_qh_i,
  input  logic [QL_W-1:0]   cls_ql_i,
  input  logic              cls_rss_i,
  input  logic              oversize_i,
  output logic              out_valid_o,
  output logic [Q_W-1:0]    queue_o,
  output logic              rss_en_o
);
  logic [NUM_PORTS-1:0]           mask;
  logic [NUM_PORTS-1:0][QH_W-1:0] base;
  rxq_num_t                       q_next;

  rxq_cfg_regs #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(mask), .base_o(base)
  );

  rxq_select #(.NUM_PORTS(NUM_PORTS)) i_sel (
    .port_i, .oversize_i, .cls_qh_i, .cls_ql_i,
    .mask_i(mask), .base_i(base), .q_o(q_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      queue_o     <= '0;
      rss_en_o    <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        queue_o  <= q_next;
        rss_en_o <= cls_rss_i;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R3
  qlow_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> queue_o[QL_W-1:0] == $past(cls_ql_i));
  // R4
  qhigh_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !oversize_i && !mask[port_i]) |=> queue_o[Q_W-1:QL_W] == $past(cls_qh_i));
  // R5
  qhigh_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask[port_i]) |=> queue_o[Q_W-1:QL_W] == $past(base[port_i]));
  // R6
  qhigh_oversize_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && oversize_i) |=> queue_o[Q_W-1:QL_W] == $past(base[port_i]));
  // R7
  rss_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> rss_en_o == $past(cls_rss_i));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(queue_o) && $stable(rss_en_o)));
endmodule

// File: tb/test_rxq_composer.sv
module test_rxq_composer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic       in_valid = 1'b0;
  logic [1:0] port = '0;
  logic [4:0] cls_qh = '0;
  logic [2:0] cls_ql = '0;
  logic       cls_rss = 1'b0;
  logic       oversize = 1'b0;
  logic       out_valid;
  logic [7:0] queue;
  logic       rss_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int mask_m  = 0;
  int base_m [4];

  always #10 clk = ~clk;

  rxq_composer i_rxq_composer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .in_valid_i(in_valid), .port_i(port),
    .cls_qh_i(cls_qh), .cls_ql_i(cls_ql), .cls_rss_i(cls_rss),
    .oversize_i(oversize), .out_valid_o(out_valid), .queue_o(queue),
    .rss_en_o(rss_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 5'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive one input, check its result one edge later
  task automatic send(input string req, input int p, input int ov, input int qh,
                      input int ql, input int rss);
    int exp_qh;
    @(negedge clk);
    in_valid = 1'b1; port = 2'(p); oversize = ov[0];
    cls_qh = 5'(qh); cls_ql = 3'(ql); cls_rss = rss[0];
    @(negedge clk);
    in_valid = 1'b0;
    exp_qh = (ov != 0 || mask_m[p]) ? base_m[p] : qh;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " queue"}, int'(queue), exp_qh * 8 + ql);
    check({req, " rss"}, int'(rss_en), rss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int qh_set [4] = '{0, 1, 17, 31};
    for (int i = 0; i < 4; i++) base_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    check("R1 valid", int'(out_valid), 0);
    check("R1 queue", int'(queue), 0);
    check("R1 rss", int'(rss_en), 0);
    // R1 bases zero: oversize forces base 0
    for (int p = 0; p < 4; p++) send("R1 base", p, 1, 31, p + 1, 0);
    // R1 mask zero: classifier high used
    for (int p = 0; p < 4; p++) send("R1 mask", p, 0, 9 + p, 5, 1);

    // R8 program bases as port*4 (first queue of 32 per port >> 3)
    for (int p = 0; p < 4; p++) begin
      write_reg(p + 1, p * 4);
      base_m[p] = p * 4;
    end

    // R2 R3 R4 R5 R6 R7 sweep
    for (int m = 0; m < 16; m++) begin
      write_reg(0, m);
      mask_m = m;
      for (int p = 0; p < 4; p++)
        for (int ov = 0; ov < 2; ov++)
          for (int ql = 0; ql < 8; ql++)
            for (int k = 0; k < 4; k++)
              for (int r = 0; r < 2; r++)
                send("R2/R3/R4/R5/R6/R7", p, ov, qh_set[k], ql, r);
    end

    // R8 unmapped writes ignored
    write_reg(0, 4'b0101);
    mask_m = 5;
    for (int a = 5; a < 8; a++) write_reg(a, 31);
    for (int p = 0; p < 4; p++) send("R8 unmapped base", p, 1, 7, 6, 1);
    for (int p = 0; p < 4; p++) send("R8 unmapped mask", p, 0, 22, 1, 0);

    // R8 base rewrite takes effect
    write_reg(3, 19);
    base_m[2] = 19;
    send("R8 rewrite", 2, 0, 3, 4, 1);

    // R9 hold while idle
    send("R9 setup", 1, 0, 13, 7, 1);
    @(negedge clk);
    in_valid = 1'b0; port = 2'd3; oversize = 1'b1;
    cls_qh = 5'd2; cls_ql = 3'd0; cls_rss = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 valid", int'(out_valid), 0);
    check("R9 queue", int'(queue), 13 * 8 + 7);
    check("R9 rss", int'(rss_en), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule